// File: doc/BRIEF.md
# Banked Nonvolatile Byte Read Store

This block models a small on-chip nonvolatile user store of 1024 bits, kept as eight banks of 128 bits. Contents change only through a programming port that handles one whole bank at a time. That port can erase a bank, write a bank, or do both in one cycle. It can also read a full bank back. Each bank is changed without touching the other seven.

The core logic has a read-only port. It gives a 7-bit address and a read strobe. One clock edge later, the selected byte appears on an 8-bit registered output. The output keeps that byte until the next strobe. The top three address bits choose the bank and the low four choose the byte within it. The core side has no write path at all, so core logic cannot change the stored contents.

Top module: `nvs_byte_store`

## Requirements
- R1: After reset, `rd_data` and `prog_rdata` are zero and every bank holds all ones, so any byte read returns 8'hFF.
- R2: A core read at address A returns bits [8*A[3:0]+7 : 8*A[3:0]] of bank A[6:4]. Byte 0 is bits [7:0] and byte 15 is bits [127:120].
- R3: A read strobe sampled at a clock edge puts the selected byte on `rd_data` right after that edge.
- R4: `rd_data` holds its value in every cycle without a read strobe.
- R5: With `prog_erase` high and `prog_write` low, the selected bank becomes all ones at the next edge.
- R6: With `prog_write` high and `prog_erase` low, the selected bank becomes its old value ANDed with `prog_wdata`. No bit can go from 0 to 1.
- R7: With `prog_erase` and `prog_write` both high, the selected bank is loaded with `prog_wdata` exactly.
- R8: An erase or write changes only the bank selected by `prog_bank`; the other banks keep their contents.
- R9: A core read in the same cycle as an erase or write to its bank returns the old contents. A read one cycle later returns the new contents.
- R10: A `prog_read` strobe loads the whole selected bank into `prog_rdata` after the edge. `prog_rdata` holds that value until the next `prog_read`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the array to all ones and clears both outputs |
| rd_en | input | 1 | Core read strobe |
| rd_addr | input | 7 | Core byte address: {bank, byte} |
| rd_data | output | 8 | Registered read byte |
| prog_bank | input | 3 | Bank selected by the programming port |
| prog_wdata | input | 128 | Bank data for writes |
| prog_erase | input | 1 | Erase strobe |
| prog_write | input | 1 | Write strobe |
| prog_read | input | 1 | Bank readback strobe |
| prog_rdata | output | 128 | Registered bank readback |

## Verification
A wrong bank or byte decode shows up on the first core read that follows a program of a distinct pattern. Because every byte of that pattern differs, a wrong decode returns a wrong byte one cycle after the strobe. A corrupt array state, such as a bit that was not erased, a bit set by a plain write, or a neighbouring bank disturbed, shows up on the next read of that bank through either port. Timing faults show up at the same cycle boundary: an erase or write racing a same-cycle read, or an output that drifts without a strobe.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_AND   = 2'd2,
        OP_LOAD  = 2'd3
    } prog_op_e;

    function automatic prog_op_e decode_op(input logic erase, input logic write);
        prog_op_e op;
        case ({erase, write})
            2'b10:   op = OP_ERASE;
            2'b01:   op = OP_AND;
            2'b11:   op = OP_LOAD;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/nvs_bank_array.sv
module nvs_bank_array
    import nvs_pkg::*;
#(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    localparam int BANK_AW  = $clog2(BANKS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  prog_op_e                            pg_op,
    input  logic [BANK_AW-1:0]                  pg_bank,
    input  logic [BANK_BITS-1:0]                pg_wdata,
    output logic [BANKS-1:0][BANK_BITS-1:0]     bank_o
);

    typedef struct packed {
        logic [BANKS-1:0][BANK_BITS-1:0] mem;
    } arr_st_t;

    arr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < BANKS; b++) begin
            if (pg_bank == BANK_AW'(b)) begin
                case (pg_op)
                    OP_ERASE: st_d.mem[b] = '1;
                    OP_AND:   st_d.mem[b] = st_q.mem[b] & pg_wdata;
                    OP_LOAD:  st_d.mem[b] = pg_wdata;
                    default:  st_d.mem[b] = st_q.mem[b];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mem: '1};
        else        st_q <= st_d;
    end

    assign bank_o = st_q.mem;

    for (genvar g = 0; g < BANKS; g++) begin : g_chk
        assert_bank_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pg_op == OP_IDLE || pg_bank != BANK_AW'(g)) |=> $stable(bank_o[g]));
        assert_erase_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pg_op == OP_ERASE && pg_bank == BANK_AW'(g)) |=> (&bank_o[g]));
        assert_write_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pg_op == OP_AND && pg_bank == BANK_AW'(g)) |=>
            ((bank_o[g] & ~$past(bank_o[g])) == '0));
        assert_load_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pg_op == OP_LOAD && pg_bank == BANK_AW'(g)) |=> (bank_o[g] == $past(pg_wdata)));
    end

endmodule

// File: rtl/nvs_byte_reader.sv
module nvs_byte_reader #(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    localparam int BYTES    = BANK_BITS / 8,
    localparam int BANK_AW  = $clog2(BANKS),
    localparam int BYTE_AW  = $clog2(BYTES),
    localparam int ADDR_W   = BANK_AW + BYTE_AW
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [BANKS-1:0][BANK_BITS-1:0] bank_i,
    output logic [7:0]                      rd_data
);

    typedef struct packed {
        logic [7:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [BANK_AW-1:0]   bank_sel;
    logic [BYTE_AW+2:0]   bit_off;

    assign bank_sel = rd_addr[ADDR_W-1:BYTE_AW];
    assign bit_off  = {rd_addr[BYTE_AW-1:0], 3'b000};

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.data = bank_i[bank_sel][bit_off +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/nvs_prog_readback.sv
module nvs_prog_readback #(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    localparam int BANK_AW  = $clog2(BANKS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pg_read,
    input  logic [BANK_AW-1:0]              pg_bank,
    input  logic [BANKS-1:0][BANK_BITS-1:0] bank_i,
    output logic [BANK_BITS-1:0]            pg_rdata
);

    typedef struct packed {
        logic [BANK_BITS-1:0] word;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pg_read) st_d.word = bank_i[pg_bank];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pg_rdata = st_q.word;

    assert_readback_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_read |=> $stable(pg_rdata));

endmodule

// File: rtl/nvs_byte_store.sv
module nvs_byte_store
    import nvs_pkg::*;
#(
    parameter int BANKS     = 8,
    parameter int BANK_BITS = 128,
    localparam int BYTES    = BANK_BITS / 8,
    localparam int BANK_AW  = $clog2(BANKS),
    localparam int ADDR_W   = BANK_AW + $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    input  logic [BANK_AW-1:0]   prog_bank,
    input  logic [BANK_BITS-1:0] prog_wdata,
    input  logic                 prog_erase,
    input  logic                 prog_write,
    input  logic                 prog_read,
    output logic [BANK_BITS-1:0] prog_rdata
);

    prog_op_e                        op;
    logic [BANKS-1:0][BANK_BITS-1:0] banks;

    assign op = decode_op(prog_erase, prog_write);

    nvs_bank_array #(.BANKS(BANKS), .BANK_BITS(BANK_BITS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_op    (op),
        .pg_bank  (prog_bank),
        .pg_wdata (prog_wdata),
        .bank_o   (banks)
    );

    nvs_byte_reader #(.BANKS(BANKS), .BANK_BITS(BANK_BITS)) u_reader (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .bank_i  (banks),
        .rd_data (rd_data)
    );

    nvs_prog_readback #(.BANKS(BANKS), .BANK_BITS(BANK_BITS)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_read  (prog_read),
        .pg_bank  (prog_bank),
        .bank_i   (banks),
        .pg_rdata (prog_rdata)
    );

endmodule

// File: tb/nvs_byte_store_tb.sv
`timescale 1ns/1ps
module nvs_byte_store_tb;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0;
    logic [6:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic [2:0]   prog_bank = '0;
    logic [127:0] prog_wdata = '0;
    logic         prog_erase = 1'b0;
    logic         prog_write = 1'b0;
    logic         prog_read = 1'b0;
    logic [127:0] prog_rdata;

    int           n_chk = 0;
    int           n_bad = 0;
    logic [127:0] model [8];
    exp_t         exp_q [$];
    logic         pend = 1'b0;
    logic [7:0]   last_exp = '0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    nvs_byte_store u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .prog_bank(prog_bank), .prog_wdata(prog_wdata), .prog_erase(prog_erase),
        .prog_write(prog_write), .prog_read(prog_read), .prog_rdata(prog_rdata)
    );

    function automatic logic [127:0] pat(input int s);
        logic [127:0] w;
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = 8'(s * 37 + i * 11 + 3);
        return w;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the expected byte one edge after each strobe
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, {120'd0, rd_data}, {120'd0, e.val});
        end
    end

    // driver: one read strobe, optionally with a program op in the same cycle
    task automatic op_cycle(input bit rd, input logic [6:0] a, input string req,
                            input bit er, input bit wr, input logic [2:0] b,
                            input logic [127:0] d);
        exp_t e;
        rd_en = rd; rd_addr = a;
        prog_erase = er; prog_write = wr; prog_bank = b; prog_wdata = d;
        if (rd) begin
            e.val = model[a[6:4]][a[3:0]*8 +: 8];
            e.req = req;
            last_exp = e.val;
            exp_q.push_back(e);
        end
        @(negedge clk);
        rd_en = 1'b0; prog_erase = 1'b0; prog_write = 1'b0;
        if (er && wr)  model[b] = d;
        else if (er)   model[b] = '1;
        else if (wr)   model[b] = model[b] & d;
    endtask

    task automatic rd(input logic [6:0] a, input string req);
        op_cycle(1'b1, a, req, 1'b0, 1'b0, 3'd0, '0);
        @(negedge clk);
    endtask

    task automatic pgm(input bit er, input bit wr, input logic [2:0] b, input logic [127:0] d);
        op_cycle(1'b0, 7'd0, "", er, wr, b, d);
    endtask

    task automatic readback(input logic [2:0] b, input string req);
        prog_bank = b; prog_read = 1'b1;
        @(negedge clk);
        prog_read = 1'b0;
        check(req, prog_rdata, model[b]);
        prog_bank = 3'd6;
        repeat (2) @(negedge clk);
        check({req, " hold"}, prog_rdata, model[b]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        // R1: reset state of both outputs
        check("R1", {120'd0, rd_data}, 128'd0);
        check("R1", prog_rdata, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(7'h00, "R1"); rd(7'h7F, "R1");
        // R7: combined erase+write loads exact data
        pgm(1'b1, 1'b1, 3'd3, pat(1));
        // R2: byte ordering and bank decode
        rd({3'd3, 4'd0}, "R2"); rd({3'd3, 4'd15}, "R2"); rd({3'd3, 4'd9}, "R7");
        // R3: byte present right after the strobe edge
        rd({3'd3, 4'd4}, "R3");
        // R4: output held across idle cycles
        repeat (4) @(negedge clk);
        check("R4", {120'd0, rd_data}, {120'd0, last_exp});
        rd_addr = 7'h00;
        @(negedge clk);
        check("R4", {120'd0, rd_data}, {120'd0, last_exp});
        // R6: write alone ANDs into stored data
        pgm(1'b0, 1'b1, 3'd3, pat(2));
        rd({3'd3, 4'd5}, "R6"); rd({3'd3, 4'd12}, "R6");
        readback(3'd3, "R6");
        // R5: erase returns a bank to all ones
        pgm(1'b1, 1'b0, 3'd3, '0);
        rd({3'd3, 4'd7}, "R5");
        readback(3'd3, "R5");
        // R8: neighbouring banks untouched
        pgm(1'b1, 1'b1, 3'd2, pat(3));
        pgm(1'b1, 1'b1, 3'd5, pat(4));
        pgm(1'b0, 1'b1, 3'd4, '0);
        rd({3'd3, 4'd1}, "R8"); rd({3'd2, 4'd6}, "R8"); rd({3'd5, 4'd11}, "R8");
        rd({3'd4, 4'd2}, "R8");
        // R9: read racing a program op sees old data, next read sees new
        op_cycle(1'b1, {3'd5, 4'd3}, "R9", 1'b1, 1'b0, 3'd5, '0);
        rd({3'd5, 4'd3}, "R9");
        op_cycle(1'b1, {3'd2, 4'd14}, "R9", 1'b0, 1'b1, 3'd2, pat(7));
        rd({3'd2, 4'd14}, "R9");
        // R10: full-bank readback through the programming port
        readback(3'd2, "R10"); readback(3'd4, "R10"); readback(3'd0, "R10");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R3", 128'(exp_q.size()), 128'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule